// File: doc/BRIEF.md
# Shared Register Port Ownership Multiplexer

This block lets two masters share a single memory-mapped register port that has address, read, write, write data, read data, read-data-valid and waitrequest signals. One master is ordinary user logic, which owns the port out of reset. The other is a debug agent. The debug agent takes the port with a one-cycle take pulse and hands it back with a one-cycle give pulse. A single ownership bit, shown on a status output, decides which master's commands reach the port. The master that does not own the port sees its waitrequest held high, so its commands stall and are never lost.

A takeover is granted only when the shared port is idle. Its waitrequest must be low and no read may still be waiting for its data. Otherwise the takeover is refused, ownership stays with the user, and a one-cycle error pulse is raised. The block records which master issued each accepted read in a small in-order tag queue. Read responses therefore go back to the master that issued them, even if ownership has changed while the read was pending. Everything runs on one clock.

Top module: `regport_owner_mux`

## Requirements
- R1: After reset the user master owns the port: `dbg_owns` is 0, `take_refused` is 0, and `usr_wait` follows `prt_wait`.
- R2: While `dbg_owns` is 0, user commands (address, read, write, write data) drive the shared port. `dbg_wait` is held at 1, and debug reads and writes do not reach the port.
- R3: While `dbg_owns` is 1, debug commands drive the shared port. `usr_wait` is held at 1, and user reads and writes never reach the port.
- R4: A `dbg_take` pulse while `dbg_owns` is 0, with `prt_wait` at 0 and no read pending, sets `dbg_owns` to 1 from the next cycle on. No refusal is raised.
- R5: A `dbg_take` pulse while `dbg_owns` is 0 is refused if `prt_wait` is 1 or at least one read is pending. `dbg_owns` stays 0, and `take_refused` is 1 for exactly the one cycle after the pulse.
- R6: A `dbg_give` pulse while `dbg_owns` is 1 clears `dbg_owns` from the next cycle on, and the user master regains the port.
- R7: A `dbg_give` pulse while `dbg_owns` is 0 has no effect. A `dbg_take` pulse while `dbg_owns` is 1 has no effect and raises no refusal.
- R8: Each `prt_rvalid` response goes only to the master that issued the oldest pending read. That master's rvalid is 1 and its rdata equals `prt_rdata`. The other master's rvalid and rdata are 0. This holds even when ownership changed after the read was issued.
- R9: A read counts as pending from the cycle it is accepted (`prt_read` high and `prt_wait` low) until its `prt_rvalid`. With `MAX_RD` reads pending, the owner's read is stalled: `prt_read` is 0 and the owner's waitrequest is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both masters and the port |
| rst | input | 1 | Synchronous active-high reset |
| usr_addr | input | ADDR_W | User master address |
| usr_read | input | 1 | User master read command |
| usr_write | input | 1 | User master write command |
| usr_wdata | input | DATA_W | User master write data |
| usr_rdata | output | DATA_W | Read data returned to the user master |
| usr_rvalid | output | 1 | Read data valid for the user master |
| usr_wait | output | 1 | Waitrequest seen by the user master |
| dbg_addr | input | ADDR_W | Debug master address |
| dbg_read | input | 1 | Debug master read command |
| dbg_write | input | 1 | Debug master write command |
| dbg_wdata | input | DATA_W | Debug master write data |
| dbg_rdata | output | DATA_W | Read data returned to the debug master |
| dbg_rvalid | output | 1 | Read data valid for the debug master |
| dbg_wait | output | 1 | Waitrequest seen by the debug master |
| dbg_take | input | 1 | One-cycle pulse asking for ownership |
| dbg_give | input | 1 | One-cycle pulse handing ownership back |
| dbg_owns | output | 1 | Ownership status: 1 while the debug master owns the port |
| take_refused | output | 1 | One-cycle pulse: a takeover was refused |
| prt_addr | output | ADDR_W | Shared port address |
| prt_read | output | 1 | Shared port read command |
| prt_write | output | 1 | Shared port write command |
| prt_wdata | output | DATA_W | Shared port write data |
| prt_rdata | input | DATA_W | Shared port read data |
| prt_rvalid | input | 1 | Shared port read data valid |
| prt_wait | input | 1 | Shared port waitrequest |

## Verification
The takeover decision is swept over every combination of port waitrequest (low or high) and pending-read count (zero to two). This separates a guard that looks only at waitrequest, or only at the pending count, from one that looks at both. Commands are sent from both masters at once in each ownership state, which exposes a selection that is inverted or leaks. Reads are issued just before a takeover, in the same cycle as one, and just before a release. The responses then show whether routing follows the issuer or the current owner. Filling the tag queue, and sending give and take pulses in the wrong ownership state, cover the stall limit and the pulses that must be ignored.

// File: rtl/regmux_pkg.sv
package regmux_pkg;
  typedef enum logic {
    OWN_USER  = 1'b0,
    OWN_DEBUG = 1'b1
  } owner_e;
endpackage

// File: rtl/regmux_tag_fifo.sv
// In-order queue of issuer tags, one per accepted read awaiting its data.
module regmux_tag_fifo
  import regmux_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  owner_e                       push_tag,
  input  logic                         pop,
  output owner_e                       head_tag,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  owner_e            tag_mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              do_push;
  logic              do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & (count != '0);
  assign head_tag = tag_mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage carries no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (do_push) tag_mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/regmux_owner_ctl.sv
// Ownership register and takeover guard.
module regmux_owner_ctl
  import regmux_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   take_req,
  input  logic   give_req,
  input  logic   port_busy,
  input  logic   rd_pending,
  output owner_e owner,
  output logic   refused
);
  always_ff @(posedge clk) begin
    if (rst) begin
      owner   <= OWN_USER;
      refused <= 1'b0;
    end else begin
      refused <= 1'b0;
      unique case (owner)
        OWN_USER: begin
          if (take_req) begin
            if (port_busy || rd_pending) refused <= 1'b1;
            else                         owner   <= OWN_DEBUG;
          end
        end
        OWN_DEBUG: begin
          if (give_req) owner <= OWN_USER;
        end
        default: owner <= OWN_USER;
      endcase
    end
  end
endmodule

// File: rtl/regmux_cmd_route.sv
// Command path: the owner reaches the port, the other master is stalled.
module regmux_cmd_route
  import regmux_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  owner_e             owner,
  input  logic               rd_full,
  input  logic [ADDR_W-1:0]  usr_addr,
  input  logic               usr_read,
  input  logic               usr_write,
  input  logic [DATA_W-1:0]  usr_wdata,
  input  logic [ADDR_W-1:0]  dbg_addr,
  input  logic               dbg_read,
  input  logic               dbg_write,
  input  logic [DATA_W-1:0]  dbg_wdata,
  input  logic               prt_wait,
  output logic [ADDR_W-1:0]  prt_addr,
  output logic               prt_read,
  output logic               prt_write,
  output logic [DATA_W-1:0]  prt_wdata,
  output logic               usr_wait,
  output logic               dbg_wait
);
  logic sel_dbg;
  logic pick_read;
  logic owner_wait;

  always_comb begin
    sel_dbg    = (owner == OWN_DEBUG);
    pick_read  = sel_dbg ? dbg_read  : usr_read;
    prt_addr   = sel_dbg ? dbg_addr  : usr_addr;
    prt_write  = sel_dbg ? dbg_write : usr_write;
    prt_wdata  = sel_dbg ? dbg_wdata : usr_wdata;
    prt_read   = pick_read & ~rd_full;
    owner_wait = prt_wait | (pick_read & rd_full);
    usr_wait   = sel_dbg ? 1'b1 : owner_wait;
    dbg_wait   = sel_dbg ? owner_wait : 1'b1;
  end
endmodule

// File: rtl/regmux_rsp_route.sv
// Response path: data goes back to the issuer recorded at the queue head.
module regmux_rsp_route
  import regmux_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  owner_e             head_tag,
  input  logic               have_pending,
  input  logic               prt_rvalid,
  input  logic [DATA_W-1:0]  prt_rdata,
  output logic [1:0]         rvalid_vec,
  output logic [DATA_W-1:0]  rdata_vec [2]
);
  for (genvar m = 0; m < 2; m++) begin : g_dest
    logic hit;
    assign hit           = prt_rvalid & have_pending & (head_tag == owner_e'(m));
    assign rvalid_vec[m] = hit;
    assign rdata_vec[m]  = hit ? prt_rdata : '0;
  end
endmodule

// File: rtl/regport_owner_mux.sv
module regport_owner_mux
  import regmux_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int MAX_RD = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  usr_addr,
  input  logic               usr_read,
  input  logic               usr_write,
  input  logic [DATA_W-1:0]  usr_wdata,
  output logic [DATA_W-1:0]  usr_rdata,
  output logic               usr_rvalid,
  output logic               usr_wait,
  input  logic [ADDR_W-1:0]  dbg_addr,
  input  logic               dbg_read,
  input  logic               dbg_write,
  input  logic [DATA_W-1:0]  dbg_wdata,
  output logic [DATA_W-1:0]  dbg_rdata,
  output logic               dbg_rvalid,
  output logic               dbg_wait,
  input  logic               dbg_take,
  input  logic               dbg_give,
  output logic               dbg_owns,
  output logic               take_refused,
  output logic [ADDR_W-1:0]  prt_addr,
  output logic               prt_read,
  output logic               prt_write,
  output logic [DATA_W-1:0]  prt_wdata,
  input  logic [DATA_W-1:0]  prt_rdata,
  input  logic               prt_rvalid,
  input  logic               prt_wait
);
  localparam int CNT_W = $clog2(MAX_RD + 1);

  owner_e             owner;
  owner_e             head_tag;
  logic [CNT_W-1:0]   rd_cnt;
  logic               rd_full;
  logic               rd_accept;
  logic [1:0]         rvalid_vec;
  logic [DATA_W-1:0]  rdata_vec [2];

  assign rd_accept = prt_read & ~prt_wait;

  regmux_owner_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .take_req   (dbg_take),
    .give_req   (dbg_give),
    .port_busy  (prt_wait),
    .rd_pending (rd_cnt != '0),
    .owner      (owner),
    .refused    (take_refused)
  );

  regmux_tag_fifo #(.DEPTH(MAX_RD)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .push     (rd_accept),
    .push_tag (owner),
    .pop      (prt_rvalid),
    .head_tag (head_tag),
    .count    (rd_cnt),
    .full     (rd_full)
  );

  regmux_cmd_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .owner     (owner),
    .rd_full   (rd_full),
    .usr_addr  (usr_addr),
    .usr_read  (usr_read),
    .usr_write (usr_write),
    .usr_wdata (usr_wdata),
    .dbg_addr  (dbg_addr),
    .dbg_read  (dbg_read),
    .dbg_write (dbg_write),
    .dbg_wdata (dbg_wdata),
    .prt_wait  (prt_wait),
    .prt_addr  (prt_addr),
    .prt_read  (prt_read),
    .prt_write (prt_write),
    .prt_wdata (prt_wdata),
    .usr_wait  (usr_wait),
    .dbg_wait  (dbg_wait)
  );

  regmux_rsp_route #(.DATA_W(DATA_W)) u_rsp (
    .head_tag     (head_tag),
    .have_pending (rd_cnt != '0),
    .prt_rvalid   (prt_rvalid),
    .prt_rdata    (prt_rdata),
    .rvalid_vec   (rvalid_vec),
    .rdata_vec    (rdata_vec)
  );

  assign usr_rvalid = rvalid_vec[OWN_USER];
  assign dbg_rvalid = rvalid_vec[OWN_DEBUG];
  assign usr_rdata  = rdata_vec[OWN_USER];
  assign dbg_rdata  = rdata_vec[OWN_DEBUG];
  assign dbg_owns   = (owner == OWN_DEBUG);
endmodule

// File: rtl/regport_owner_mux_chk.sv
module regport_owner_mux_chk #(
  parameter int MAX_RD = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             usr_read,
  input logic             usr_write,
  input logic             usr_wait,
  input logic             usr_rvalid,
  input logic             dbg_read,
  input logic             dbg_write,
  input logic             dbg_wait,
  input logic             dbg_rvalid,
  input logic             dbg_take,
  input logic             dbg_give,
  input logic             dbg_owns,
  input logic             take_refused,
  input logic             prt_read,
  input logic             prt_write,
  input logic             prt_rvalid,
  input logic             prt_wait,
  input logic [CNT_W-1:0] rd_cnt
);
  a_r1_reset_user: assert property (@(posedge clk)
    $fell(rst) |-> (!dbg_owns && !take_refused));

  a_r2_debug_stalled: assert property (@(posedge clk) disable iff (rst)
    !dbg_owns |-> dbg_wait);

  a_r2_debug_blocked: assert property (@(posedge clk) disable iff (rst)
    (!dbg_owns && !usr_write && !usr_read && (dbg_write || dbg_read)) |-> (!prt_write && !prt_read));

  a_r3_user_stalled: assert property (@(posedge clk) disable iff (rst)
    dbg_owns |-> usr_wait);

  a_r3_user_blocked: assert property (@(posedge clk) disable iff (rst)
    (dbg_owns && !dbg_write && !dbg_read && (usr_write || usr_read)) |-> (!prt_write && !prt_read));

  a_r4_take_granted: assert property (@(posedge clk) disable iff (rst)
    (!dbg_owns && dbg_take && !prt_wait && rd_cnt == '0) |=> (dbg_owns && !take_refused));

  a_r5_take_refused: assert property (@(posedge clk) disable iff (rst)
    (!dbg_owns && dbg_take && (prt_wait || rd_cnt != '0)) |=> (!dbg_owns && take_refused));

  a_r5_refuse_cause: assert property (@(posedge clk) disable iff (rst)
    take_refused |-> $past(dbg_take));

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (dbg_owns && dbg_give) |=> !dbg_owns);

  a_r7_give_ignored: assert property (@(posedge clk) disable iff (rst)
    (!dbg_owns && dbg_give && !dbg_take) |=> !dbg_owns);

  a_r7_take_when_owned: assert property (@(posedge clk) disable iff (rst)
    dbg_owns |=> !take_refused);

  a_r8_one_dest: assert property (@(posedge clk) disable iff (rst)
    $onehot0({usr_rvalid, dbg_rvalid}) && ((usr_rvalid || dbg_rvalid) -> prt_rvalid));

  a_r9_limit: assert property (@(posedge clk) disable iff (rst)
    (rd_cnt == CNT_W'(MAX_RD)) |-> !prt_read);
endmodule

bind regport_owner_mux regport_owner_mux_chk #(.MAX_RD(MAX_RD), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .usr_read     (usr_read),
  .usr_write    (usr_write),
  .usr_wait     (usr_wait),
  .usr_rvalid   (usr_rvalid),
  .dbg_read     (dbg_read),
  .dbg_write    (dbg_write),
  .dbg_wait     (dbg_wait),
  .dbg_rvalid   (dbg_rvalid),
  .dbg_take     (dbg_take),
  .dbg_give     (dbg_give),
  .dbg_owns     (dbg_owns),
  .take_refused (take_refused),
  .prt_read     (prt_read),
  .prt_write    (prt_write),
  .prt_rvalid   (prt_rvalid),
  .prt_wait     (prt_wait),
  .rd_cnt       (rd_cnt)
);

// File: tb/regport_owner_mux_bench.sv
module regport_owner_mux_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int MR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] usr_addr = '0, dbg_addr = '0;
  logic usr_read = 0, usr_write = 0, dbg_read = 0, dbg_write = 0;
  logic [DW-1:0] usr_wdata = '0, dbg_wdata = '0, prt_rdata = '0;
  logic dbg_take = 0, dbg_give = 0, prt_rvalid = 0, prt_wait = 0;
  logic [DW-1:0] usr_rdata, dbg_rdata, prt_wdata;
  logic usr_rvalid, usr_wait, dbg_rvalid, dbg_wait, dbg_owns, take_refused;
  logic [AW-1:0] prt_addr;
  logic prt_read, prt_write;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  regport_owner_mux #(.ADDR_W(AW), .DATA_W(DW), .MAX_RD(MR)) u_regport_owner_mux (
    .clk(clk), .rst(rst),
    .usr_addr(usr_addr), .usr_read(usr_read), .usr_write(usr_write), .usr_wdata(usr_wdata),
    .usr_rdata(usr_rdata), .usr_rvalid(usr_rvalid), .usr_wait(usr_wait),
    .dbg_addr(dbg_addr), .dbg_read(dbg_read), .dbg_write(dbg_write), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid), .dbg_wait(dbg_wait),
    .dbg_take(dbg_take), .dbg_give(dbg_give), .dbg_owns(dbg_owns), .take_refused(take_refused),
    .prt_addr(prt_addr), .prt_read(prt_read), .prt_write(prt_write), .prt_wdata(prt_wdata),
    .prt_rdata(prt_rdata), .prt_rvalid(prt_rvalid), .prt_wait(prt_wait)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_cmds();
    usr_read = 0; usr_write = 0; dbg_read = 0; dbg_write = 0;
    dbg_take = 0; dbg_give = 0; prt_rvalid = 0; prt_wait = 0;
  endtask

  // one user read accepted at the next edge
  task automatic user_read_once();
    usr_read = 1; prt_wait = 0;
    @(negedge clk);
    usr_read = 0;
  endtask

  // return one response; expect_dbg says which master must receive it
  task automatic respond(input logic [DW-1:0] val, input bit expect_dbg, input string req);
    prt_rvalid = 1; prt_rdata = val;
    #1;
    check(req, "usr_rvalid", 32'(usr_rvalid), 32'(!expect_dbg));
    check(req, "dbg_rvalid", 32'(dbg_rvalid), 32'(expect_dbg));
    check(req, "usr_rdata", 32'(usr_rdata), expect_dbg ? 32'h0 : 32'(val));
    check(req, "dbg_rdata", 32'(dbg_rdata), expect_dbg ? 32'(val) : 32'h0);
    @(negedge clk);
    prt_rvalid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", "dbg_owns", 32'(dbg_owns), 0);
    check("R1", "take_refused", 32'(take_refused), 0);
    prt_wait = 1; #1;
    check("R1", "usr_wait follows port", 32'(usr_wait), 1);
    prt_wait = 0; #1;
    check("R1", "usr_wait follows port low", 32'(usr_wait), 0);

    // R2 user owns: both masters command at once, user wins
    usr_addr = 8'h3c; usr_write = 1; usr_wdata = 16'hbeef;
    dbg_addr = 8'hc3; dbg_read = 1; dbg_wdata = 16'h1234;
    #1;
    check("R2", "prt_addr", 32'(prt_addr), 32'h3c);
    check("R2", "prt_wdata", 32'(prt_wdata), 32'hbeef);
    check("R2", "prt_write", 32'(prt_write), 1);
    check("R2", "prt_read", 32'(prt_read), 0);
    check("R2", "dbg_wait", 32'(dbg_wait), 1);
    usr_write = 0; #1;
    check("R2", "debug read blocked", 32'(prt_read), 0);
    clear_cmds();
    @(negedge clk);

    // R4/R5 sweep over port waitrequest and pending reads
    for (int pw = 0; pw < 2; pw++) begin
      for (int n = 0; n < 3; n++) begin
        bit grant;
        grant = (pw == 0) && (n == 0);
        for (int k = 0; k < n; k++) user_read_once();
        prt_wait = pw[0]; dbg_take = 1;
        @(negedge clk);
        dbg_take = 0; prt_wait = 0;
        check(grant ? "R4" : "R5", $sformatf("owns pw=%0d n=%0d", pw, n), 32'(dbg_owns), 32'(grant));
        check(grant ? "R4" : "R5", $sformatf("refused pw=%0d n=%0d", pw, n), 32'(take_refused), 32'(!grant));
        @(negedge clk);
        check("R5", "refusal lasts one cycle", 32'(take_refused), 0);
        for (int k = 0; k < n; k++) respond(16'(16'h100 + k), 1'b0, "R8");
        if (grant) begin
          dbg_give = 1;
          @(negedge clk);
          dbg_give = 0;
          check("R6", "released", 32'(dbg_owns), 0);
        end
      end
    end

    // R7 give while user owns
    dbg_give = 1;
    @(negedge clk);
    dbg_give = 0;
    check("R7", "give ignored", 32'(dbg_owns), 0);
    check("R7", "give raises nothing", 32'(take_refused), 0);

    // take, then R3 lockout of user
    dbg_take = 1;
    @(negedge clk);
    dbg_take = 0;
    check("R4", "granted", 32'(dbg_owns), 1);
    usr_write = 1; usr_read = 1; usr_addr = 8'h11; dbg_addr = 8'h22;
    #1;
    check("R3", "user write blocked", 32'(prt_write), 0);
    check("R3", "user read blocked", 32'(prt_read), 0);
    check("R3", "usr_wait held", 32'(usr_wait), 1);
    check("R3", "debug addr routed", 32'(prt_addr), 32'h22);
    check("R3", "dbg_wait follows port", 32'(dbg_wait), 0);
    usr_write = 0; usr_read = 0;
    dbg_take = 1;
    @(negedge clk);
    dbg_take = 0;
    check("R7", "take while owned no refusal", 32'(take_refused), 0);
    check("R7", "take while owned keeps", 32'(dbg_owns), 1);

    // R8 debug read pending across release
    dbg_read = 1;
    @(negedge clk);
    dbg_read = 0; dbg_give = 1;
    @(negedge clk);
    dbg_give = 0;
    check("R6", "release with read pending", 32'(dbg_owns), 0);
    #1;
    check("R6", "user regains wait", 32'(usr_wait), 0);
    respond(16'ha5a5, 1'b1, "R8");

    // R8 user read in same cycle as take
    usr_read = 1; dbg_take = 1;
    @(negedge clk);
    usr_read = 0; dbg_take = 0;
    check("R4", "granted with same-cycle read", 32'(dbg_owns), 1);
    respond(16'h5a5a, 1'b0, "R8");
    dbg_give = 1;
    @(negedge clk);
    dbg_give = 0;

    // R9 pending-read limit
    usr_read = 1;
    repeat (MR) @(negedge clk);
    #1;
    check("R9", "read stalled at limit", 32'(prt_read), 0);
    check("R9", "usr_wait at limit", 32'(usr_wait), 1);
    usr_read = 0;
    @(negedge clk);
    for (int k = 0; k < MR; k++) respond(16'(16'h200 + k), 1'b0, "R8");
    usr_read = 1; #1;
    check("R9", "read flows after drain", 32'(prt_read), 1);
    usr_read = 0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule